// File: doc/BRIEF.md
# Flash write permission controller

This block sits in the register space of a small microcontroller and decides where the core's external-data move writes land. Normally they go to data RAM. When software sets a one-shot program-write bit, a move write is steered into program flash instead. The flash write strobe is only issued if a 4-bit unlock field holds the key value. The block also drives two permission flags for the debug and serial-slave ports. Reading the flash is allowed whenever the secure strap is low. Writing the flash through those ports also needs the unlock key.

The program-write bit is deliberately hard to leave on. The flash side clears it after every byte it programs. While the global interrupt enable is high, register writes to it are ignored, so an interrupt handler cannot catch a half-armed state. A move write that reaches the flash path without the key is dropped, and a one-cycle error pulse is raised.

Top module: `fwp_ctrl`

## Requirements
- R1: After reset the program-write bit and the unlock field are 0, mem_sel_o is 0, and both register reads return 0 with secure_i high.
- R2: With the program-write bit at 0, a move write (xmove_wr_i) raises ram_wr_o in the same cycle. In that cycle flash_wr_o and wr_err_o stay low and mem_sel_o is 0.
- R3: With the program-write bit at 1 and the unlock field equal to 2, a move write raises flash_wr_o in the same cycle, and ram_wr_o stays low. mem_sel_o follows the program-write bit.
- R4: With the program-write bit at 1 and the unlock field not equal to 2, a move write raises neither ram_wr_o nor flash_wr_o. It raises wr_err_o for that cycle.
- R5: A flash_byte_done_i pulse clears the program-write bit at the next clock edge. The clear wins over a register write that tries to set the bit in the same cycle.
- R6: A register write to the control register (reg_sel_i = 0, bit 0 of reg_wdata_i) changes the program-write bit only while irq_en_i is low. While irq_en_i is high it is ignored, whether it tries to set or to clear the bit.
- R7: rd_perm_o equals the inverse of secure_i.
- R8: wr_perm_o is 1 exactly when the unlock field equals 2 and secure_i is low.
- R9: A register write with reg_sel_i = 1 loads the unlock field from reg_wdata_i[3:0], whatever the state of irq_en_i. Bits [7:4] of that write are ignored.
- R10: Reads are combinational. Selecting reg_sel_i = 0 returns the program-write bit in bit 0. Selecting reg_sel_i = 1 returns the unlock field in [3:0], rd_perm in bit 4 and wr_perm in bit 5. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 control, 1 unlock/status |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for the selected register |
| irq_en_i | input | 1 | Global interrupt enable level |
| secure_i | input | 1 | Security strap |
| xmove_wr_i | input | 1 | External-data move write request from the core |
| flash_byte_done_i | input | 1 | Pulse when the flash has programmed one byte |
| mem_sel_o | output | 1 | Steering select: 1 flash, 0 data RAM |
| ram_wr_o | output | 1 | Data RAM write strobe |
| flash_wr_o | output | 1 | Flash program strobe |
| wr_err_o | output | 1 | Dropped flash write pulse |
| rd_perm_o | output | 1 | Port flash read permission |
| wr_perm_o | output | 1 | Port flash write permission |

## Verification
Two things can hit the program-write bit in the same cycle: the self-clear from a finished flash byte, and a register write that sets the bit. A directed case raises flash_byte_done_i together with a control write of 1 while interrupts are disabled. The bit is expected to read 0 afterwards. The random phase draws the done pulse and the register writes independently, so the collision recurs under random interrupt levels. Every cycle is judged against a reference model in the bench that gives the clear priority.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned UNLOCK_W = 4;
  localparam logic [UNLOCK_W-1:0] UNLOCK_KEY = UNLOCK_W'(2);

  typedef enum logic {
    SEL_CTRL   = 1'b0,
    SEL_UNLOCK = 1'b1
  } reg_sel_e;

  localparam int unsigned RD_PERM_BIT = UNLOCK_W;
  localparam int unsigned WR_PERM_BIT = UNLOCK_W + 1;
endpackage

// File: rtl/fwp_pwe_reg.sv
module fwp_pwe_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic wdata_i,
  input  logic irq_en_i,
  input  logic clr_i,
  output logic pwe_o
);
  logic pwe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               pwe_q <= 1'b0;
    else if (clr_i)            pwe_q <= 1'b0;   // byte done beats software set
    else if (wr_i && !irq_en_i) pwe_q <= wdata_i;
  end

  assign pwe_o = pwe_q;

  assert_self_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !pwe_q);

  assert_irq_lock_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_i && !clr_i) |=> $stable(pwe_q));
endmodule

// File: rtl/fwp_unlock_reg.sv
module fwp_unlock_reg
  import fwp_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [UNLOCK_W-1:0] wdata_i,
  output logic [UNLOCK_W-1:0] unlock_o,
  output logic                key_ok_o
);
  logic [UNLOCK_W-1:0] unlock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   unlock_q <= '0;
    else if (wr_i) unlock_q <= wdata_i;
  end

  assign unlock_o = unlock_q;
  assign key_ok_o = (unlock_q == UNLOCK_KEY);

  assert_unlock_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> unlock_q == $past(wdata_i));
endmodule

// File: rtl/fwp_steer.sv
module fwp_steer (
  input  logic xmove_wr_i,
  input  logic pwe_i,
  input  logic key_ok_i,
  output logic mem_sel_o,
  output logic ram_wr_o,
  output logic flash_wr_o,
  output logic wr_err_o
);
  always_comb begin
    mem_sel_o  = pwe_i;
    ram_wr_o   = xmove_wr_i && !pwe_i;
    flash_wr_o = xmove_wr_i && pwe_i && key_ok_i;
    wr_err_o   = xmove_wr_i && pwe_i && !key_ok_i;
  end

  always_comb begin
    assert_one_target_R4: assert ($onehot0({ram_wr_o, flash_wr_o, wr_err_o}));
  end
endmodule

// File: rtl/fwp_ctrl.sv
module fwp_ctrl
  import fwp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              irq_en_i,
  input  logic              secure_i,
  input  logic              xmove_wr_i,
  input  logic              flash_byte_done_i,
  output logic              mem_sel_o,
  output logic              ram_wr_o,
  output logic              flash_wr_o,
  output logic              wr_err_o,
  output logic              rd_perm_o,
  output logic              wr_perm_o
);
  logic                pwe;
  logic                key_ok;
  logic [UNLOCK_W-1:0] unlock;
  logic                ctrl_wr, unl_wr;

  assign ctrl_wr = reg_we_i && (reg_sel_e'(reg_sel_i) == SEL_CTRL);
  assign unl_wr  = reg_we_i && (reg_sel_e'(reg_sel_i) == SEL_UNLOCK);

  fwp_pwe_reg u_pwe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (ctrl_wr),
    .wdata_i  (reg_wdata_i[0]),
    .irq_en_i (irq_en_i),
    .clr_i    (flash_byte_done_i),
    .pwe_o    (pwe)
  );

  fwp_unlock_reg u_unlock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (unl_wr),
    .wdata_i  (reg_wdata_i[UNLOCK_W-1:0]),
    .unlock_o (unlock),
    .key_ok_o (key_ok)
  );

  fwp_steer u_steer (
    .xmove_wr_i (xmove_wr_i),
    .pwe_i      (pwe),
    .key_ok_i   (key_ok),
    .mem_sel_o  (mem_sel_o),
    .ram_wr_o   (ram_wr_o),
    .flash_wr_o (flash_wr_o),
    .wr_err_o   (wr_err_o)
  );

  assign rd_perm_o = !secure_i;
  assign wr_perm_o = key_ok && !secure_i;

  always_comb begin
    reg_rdata_o = '0;
    if (reg_sel_e'(reg_sel_i) == SEL_CTRL) begin
      reg_rdata_o[0] = pwe;
    end else begin
      reg_rdata_o[UNLOCK_W-1:0] = unlock;
      reg_rdata_o[RD_PERM_BIT]  = rd_perm_o;
      reg_rdata_o[WR_PERM_BIT]  = wr_perm_o;
    end
  end

  always_comb begin
    assert_wr_implies_rd_R8: assert (!wr_perm_o || rd_perm_o);
  end

  assert_flash_needs_key_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_wr_o |-> (unlock == UNLOCK_KEY) && mem_sel_o);

  assert_ram_path_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xmove_wr_i && !mem_sel_o) |-> ram_wr_o && !flash_wr_o);
endmodule

// File: tb/tb_fwp_ctrl.sv
module tb_fwp_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 0, sel = 0, irq = 0, sec = 1, xmv = 0, done = 0;
  logic [7:0] wd = 0;
  logic [7:0] rd;
  logic       msel, ramw, flw, err, rp, wp;

  int checks = 0, fails = 0;
  logic       m_pwe = 0;
  logic [3:0] m_unl = 0;

  always #4 clk = ~clk;  // 125 MHz

  fwp_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_sel_i(sel),
    .reg_wdata_i(wd), .reg_rdata_o(rd), .irq_en_i(irq), .secure_i(sec),
    .xmove_wr_i(xmv), .flash_byte_done_i(done), .mem_sel_o(msel),
    .ram_wr_o(ramw), .flash_wr_o(flw), .wr_err_o(err),
    .rd_perm_o(rp), .wr_perm_o(wp)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic s);
    logic okk = (m_unl == 4'd2);
    if (!s) return {7'b0, m_pwe};
    return {2'b00, okk && !sec, !sec, m_unl};
  endfunction

  function automatic logic exp_next_pwe();
    if (done) return 1'b0;
    if (we && !sel && !irq) return wd[0];
    return m_pwe;
  endfunction

  // check all outputs against model, then advance one clock
  task automatic step();
    logic ok;
    #1;
    ok = (m_unl == 4'd2);
    chk("R10", rd, exp_rd(sel));
    chk("R2", {7'b0, msel}, {7'b0, m_pwe});
    chk("R2", {7'b0, ramw}, {7'b0, xmv && !m_pwe});
    chk("R3", {7'b0, flw}, {7'b0, xmv && m_pwe && ok});
    chk("R4", {7'b0, err}, {7'b0, xmv && m_pwe && !ok});
    chk("R7", {7'b0, rp}, {7'b0, !sec});
    chk("R8", {7'b0, wp}, {7'b0, ok && !sec});
    @(posedge clk);
    m_pwe = exp_next_pwe();
    if (we && sel) m_unl = wd[3:0];  // R9
    @(negedge clk);
    we = 0; xmv = 0; done = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    sel = 0; #1 chk("R1", rd, 8'h00);
    sel = 1; #1 chk("R1", rd, 8'h00);
    chk("R1", {7'b0, msel}, 8'h00);
    rst_n = 1;
    @(negedge clk);

    // R2 RAM path
    xmv = 1; step();
    // R4 set pwe without key, then write -> error
    we = 1; sel = 0; wd = 8'h01; irq = 0; step();
    xmv = 1; step();
    // R9 load key with junk upper bits, under irq
    irq = 1; we = 1; sel = 1; wd = 8'hF2; step();
    sel = 1; sec = 0; step();
    // R3 flash path
    xmv = 1; step();
    // R6 clear ignored while irq high
    we = 1; sel = 0; wd = 8'h00; step();
    sel = 0; step();
    // R5 byte done clears
    done = 1; step();
    // R5 collision: set and clear same cycle
    irq = 0; we = 1; sel = 0; wd = 8'h01; done = 1; step();
    sel = 0; step();
    // R6 set ignored while irq high
    irq = 1; we = 1; sel = 0; wd = 8'h01; step();
    sel = 0; step();

    // random phase
    for (int i = 0; i < 3000; i++) begin
      we   = ($urandom % 3) == 0;
      sel  = $urandom % 2;
      wd   = (($urandom % 3) == 0) ? (8'h02 | (8'($urandom) & 8'hF0)) : 8'($urandom);
      irq  = $urandom % 2;
      sec  = $urandom % 2;
      xmv  = $urandom % 2;
      done = ($urandom % 4) == 0;
      step();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule